// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block produces the status word that a parallel NOR flash places on its data bus while its internal program or erase algorithm runs. It follows the algorithm state through seven states: idle, the erase timeout window, erasing, erase suspended, programming, failed, and a timed wait that is used when no selected sector can be erased. It also watches host read cycles. A read cycle runs while chip select and output enable are both low, and it ends when either one rises. From the state and the reads, the block builds a status word that the surrounding device drives in place of array data.

The word carries two toggle bits. The mode toggle inverts on reads while an algorithm runs. The sector toggle inverts only on reads that address a sector chosen for erase, and it keeps doing so during suspend. The word also carries a sticky failure flag and an erase timer flag. The erase and program start strobes come from the command decoder and are taken on the final write pulse of a command sequence. The finish and pulse-limit inputs come from the algorithm counter. The latched sector masks tell the array which sectors to erase.

Top module: `flash_status_gen`

## Requirements
- R1: After reset and in idle, `stat_drive` is 0, `stat_word` is 0 and `erase_sectors` is 0. Whenever `stat_drive` is 0, `stat_word` is 0.
- R2: The status word has this layout: bit 6 is the mode toggle, bit 5 is the fail flag, bit 3 is the erase timer and bit 2 is the sector toggle. All other bits are 0. Bit 6 inverts exactly once for each completed read cycle, at any sector, in the window, erasing, programming, protected-wait and failed states. A read cycle ends when `cs_n` or `oe_n` rises.
- R3: In the suspended state, bit 6 holds its value across reads.
- R4: At the end of a read, bit 2 inverts only if the sector read (`rd_sect`) is set in the selected mask latched at erase start, and only in the window, erasing or suspended states. Otherwise bit 2 holds.
- R5: Bit 3 is 0 for exactly TIMEOUT_CYC cycles after the erase start strobe. It is then 1 while erasing or suspended.
- R6: If the selected mask ANDed with the inverted protect mask is zero at erase start, the block drives status for PWAIT_CYC cycles. During that time bit 3 is 0 and bit 6 toggles on reads. The block then returns to idle.
- R7: While erasing, `erase_sectors` equals the selected mask with the protected sectors cleared, both latched at erase start. In every other state it is 0.
- R8: `pulse_limit` while erasing or programming enters the failed state, which sets bit 5 to 1 and bit 3 to 0.
- R9: A program start with `prog_bad` high (an attempt to turn a 0 into a 1) enters the failed state at once.
- R10: The failed state holds until `reset_cmd`, which returns the block to idle. `reset_cmd` has no effect in any other state.
- R11: `suspend_req` while erasing enters suspend. `resume_req` in suspend returns to erasing. `done_in` while erasing or programming returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_sect | input | SECT_AW | Sector field of the read address |
| start_erase | input | 1 | Erase command accepted (final write pulse) |
| start_prog | input | 1 | Program command accepted (final write pulse) |
| prog_bad | input | 1 | Program would turn a stored 0 into a 1 |
| suspend_req | input | 1 | Erase suspend command |
| resume_req | input | 1 | Erase resume command |
| done_in | input | 1 | Algorithm finished |
| pulse_limit | input | 1 | Internal pulse count limit exceeded |
| reset_cmd | input | 1 | Read/reset command |
| sel_mask | input | 2**SECT_AW | Sectors chosen for erase |
| prot_mask | input | 2**SECT_AW | Protected sectors |
| stat_drive | output | 1 | Drive status in place of array data |
| stat_word | output | 8 | Status word |
| erase_sectors | output | 2**SECT_AW | Sectors being erased |

## Verification
A wrong internal state shows at the ports on the next read cycle. A lost or doubled inversion shows as a mismatch in bit 6 or bit 2 when the following read is compared, and a wrong state shows in bits 3 and 5 and in `stat_drive` within one cycle of the strobe that caused it. A window or wait counter that is off by one shows as a bit 3 or `stat_drive` edge one cycle early or late. A mask latched wrongly shows in `erase_sectors` and in the sector toggle pattern across a sweep of all selected masks and sectors.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EWIN,
        ST_ERASE,
        ST_SUSP,
        ST_PROG,
        ST_FAIL,
        ST_PWAIT
    } fsg_state_e;
endpackage

// File: rtl/fsg_strobe.sv
module fsg_strobe #(
    parameter int SECT_AW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               oe_n,
    input  logic [SECT_AW-1:0] sect_in,
    output logic               rd_end,
    output logic [SECT_AW-1:0] rd_sect_lat
);
    typedef struct packed {
        logic               rd;
        logic [SECT_AW-1:0] sect;
    } strb_t;

    strb_t strb_d, strb_q;
    logic  rd_now;

    always_comb begin
        rd_now = ~cs_n & ~oe_n;
        strb_d = strb_q;
        strb_d.rd = rd_now;
        if (rd_now) strb_d.sect = sect_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q <= '0;
        else        strb_q <= strb_d;
    end

    assign rd_end      = strb_q.rd & ~rd_now;
    assign rd_sect_lat = strb_q.sect;

    // a read cycle cannot end twice in a row
    p_single_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_end |=> !rd_end);
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
#(
    parameter int NUM_SECT    = 4,
    parameter int TIMEOUT_CYC = 20,
    parameter int PWAIT_CYC   = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_erase,
    input  logic                start_prog,
    input  logic                prog_bad,
    input  logic                suspend_req,
    input  logic                resume_req,
    input  logic                done_in,
    input  logic                pulse_limit,
    input  logic                reset_cmd,
    input  logic [NUM_SECT-1:0] sel_mask,
    input  logic [NUM_SECT-1:0] prot_mask,
    output fsg_state_e          state,
    output logic [NUM_SECT-1:0] sel_lat,
    output logic [NUM_SECT-1:0] erase_sectors
);
    localparam int MAX_CYC = (TIMEOUT_CYC > PWAIT_CYC) ? TIMEOUT_CYC : PWAIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        fsg_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [NUM_SECT-1:0] sel;
        logic [NUM_SECT-1:0] eff;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.cnt = '0;
                if (start_erase) begin
                    ctl_d.sel = sel_mask;
                    ctl_d.eff = sel_mask & ~prot_mask;
                    ctl_d.st  = ((sel_mask & ~prot_mask) == '0) ? ST_PWAIT : ST_EWIN;
                end else if (start_prog) begin
                    ctl_d.st = prog_bad ? ST_FAIL : ST_PROG;
                end
            end
            ST_EWIN: begin
                if (ctl_q.cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
                    ctl_d.st  = ST_ERASE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_ERASE: begin
                if (pulse_limit)      ctl_d.st = ST_FAIL;
                else if (done_in)     ctl_d.st = ST_IDLE;
                else if (suspend_req) ctl_d.st = ST_SUSP;
            end
            ST_SUSP: begin
                if (resume_req) ctl_d.st = ST_ERASE;
            end
            ST_PROG: begin
                if (pulse_limit)  ctl_d.st = ST_FAIL;
                else if (done_in) ctl_d.st = ST_IDLE;
            end
            ST_FAIL: begin
                if (reset_cmd) ctl_d.st = ST_IDLE;
            end
            ST_PWAIT: begin
                if (ctl_q.cnt == CNT_W'(PWAIT_CYC - 1)) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, cnt: '0, sel: '0, eff: '0};
        else        ctl_q <= ctl_d;
    end

    assign state         = ctl_q.st;
    assign sel_lat       = ctl_q.sel;
    assign erase_sectors = (ctl_q.st == ST_ERASE) ? ctl_q.eff : '0;

    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL && !reset_cmd) |=> state == ST_FAIL);

    p_reset_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && reset_cmd && !pulse_limit && !done_in && !suspend_req)
        |=> state == ST_ERASE);

    p_erase_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ERASE) ##1 (state == ST_ERASE)
        |-> ($past(state) == ST_EWIN || $past(state) == ST_SUSP));

    p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWAIT) |-> ctl_q.cnt < CNT_W'(PWAIT_CYC));

    p_fail_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && pulse_limit) |=> state == ST_FAIL);
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
    import fsg_pkg::*;
#(
    parameter int SECT_AW  = 2,
    parameter int NUM_SECT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_end,
    input  logic [SECT_AW-1:0]  rd_sect,
    input  fsg_state_e          state,
    input  logic [NUM_SECT-1:0] sel_lat,
    output logic                tog_mode,
    output logic                tog_sect
);
    typedef struct packed {
        logic t6;
        logic t2;
    } tog_t;

    tog_t tog_d, tog_q;
    logic mode_en, sect_en;

    always_comb begin
        mode_en = (state == ST_EWIN) || (state == ST_ERASE) || (state == ST_PROG) ||
                  (state == ST_FAIL) || (state == ST_PWAIT);
        sect_en = ((state == ST_EWIN) || (state == ST_ERASE) || (state == ST_SUSP)) &&
                  sel_lat[rd_sect];
        tog_d = tog_q;
        if (rd_end && mode_en) tog_d.t6 = ~tog_q.t6;
        if (rd_end && sect_en) tog_d.t2 = ~tog_q.t2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= '0;
        else        tog_q <= tog_d;
    end

    assign tog_mode = tog_q.t6;
    assign tog_sect = tog_q.t2;

    p_mode_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && state == ST_ERASE) |=> tog_mode != $past(tog_mode));

    p_mode_hold_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && state == ST_SUSP) |=> $stable(tog_mode));

    p_sect_quiet_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> $stable(tog_sect));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int  SECT_AW     = 2,
    parameter int  TIMEOUT_CYC = 20,
    parameter int  PWAIT_CYC   = 30,
    localparam int NUM_SECT    = 2 ** SECT_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                oe_n,
    input  logic [SECT_AW-1:0]  rd_sect,
    input  logic                start_erase,
    input  logic                start_prog,
    input  logic                prog_bad,
    input  logic                suspend_req,
    input  logic                resume_req,
    input  logic                done_in,
    input  logic                pulse_limit,
    input  logic                reset_cmd,
    input  logic [NUM_SECT-1:0] sel_mask,
    input  logic [NUM_SECT-1:0] prot_mask,
    output logic                stat_drive,
    output logic [7:0]          stat_word,
    output logic [NUM_SECT-1:0] erase_sectors
);
    fsg_state_e          state;
    logic [NUM_SECT-1:0] sel_lat;
    logic                rd_end;
    logic [SECT_AW-1:0]  sect_lat;
    logic                tog_mode, tog_sect;

    fsg_strobe #(.SECT_AW(SECT_AW)) i_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n),
        .sect_in(rd_sect), .rd_end(rd_end), .rd_sect_lat(sect_lat)
    );

    fsg_ctrl #(
        .NUM_SECT(NUM_SECT), .TIMEOUT_CYC(TIMEOUT_CYC), .PWAIT_CYC(PWAIT_CYC)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_erase(start_erase), .start_prog(start_prog),
        .prog_bad(prog_bad), .suspend_req(suspend_req), .resume_req(resume_req),
        .done_in(done_in), .pulse_limit(pulse_limit), .reset_cmd(reset_cmd),
        .sel_mask(sel_mask), .prot_mask(prot_mask), .state(state),
        .sel_lat(sel_lat), .erase_sectors(erase_sectors)
    );

    fsg_toggle #(.SECT_AW(SECT_AW), .NUM_SECT(NUM_SECT)) i_toggle (
        .clk(clk), .rst_n(rst_n), .rd_end(rd_end), .rd_sect(sect_lat),
        .state(state), .sel_lat(sel_lat), .tog_mode(tog_mode), .tog_sect(tog_sect)
    );

    always_comb begin
        stat_drive = (state != ST_IDLE);
        stat_word  = '0;
        if (stat_drive) begin
            stat_word[6] = tog_mode;
            stat_word[5] = (state == ST_FAIL);
            stat_word[3] = (state == ST_ERASE) || (state == ST_SUSP);
            stat_word[2] = tog_sect;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_drive |-> (stat_word == 8'h00 && erase_sectors == '0));

    p_fail_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL) |-> (stat_word[5] && !stat_word[3]));

    p_erase_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ERASE) |-> erase_sectors == '0);
endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    localparam int SAW = 2;
    localparam int NS  = 4;
    localparam int TO  = 20;
    localparam int PW  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, oe_n = 1'b1;
    logic [SAW-1:0] rd_sect = '0;
    logic start_erase = 0, start_prog = 0, prog_bad = 0, suspend_req = 0;
    logic resume_req = 0, done_in = 0, pulse_limit = 0, reset_cmd = 0;
    logic [NS-1:0] sel_mask = '0, prot_mask = '0;
    logic stat_drive;
    logic [7:0] stat_word;
    logic [NS-1:0] erase_sectors;

    int n_tests = 0, n_fail = 0;
    bit e6 = 0, e2 = 0, f5 = 0, b3 = 0;
    logic [NS-1:0] selb = '0;

    always #5 clk = ~clk;

    flash_status_gen #(.SECT_AW(SAW), .TIMEOUT_CYC(TO), .PWAIT_CYC(PW)) i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .rd_sect(rd_sect),
        .start_erase(start_erase), .start_prog(start_prog), .prog_bad(prog_bad),
        .suspend_req(suspend_req), .resume_req(resume_req), .done_in(done_in),
        .pulse_limit(pulse_limit), .reset_cmd(reset_cmd), .sel_mask(sel_mask),
        .prot_mask(prot_mask), .stat_drive(stat_drive), .stat_word(stat_word),
        .erase_sectors(erase_sectors)
    );

    function automatic logic [7:0] ew();
        return {1'b0, e6, f5, 1'b0, b3, e2, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // 0 erase, 1 prog, 2 bad prog, 3 suspend, 4 resume, 5 done, 6 limit, 7 reset
    task automatic pulse(input int k);
        case (k)
            0: start_erase = 1;
            1: start_prog = 1;
            2: begin start_prog = 1; prog_bad = 1; end
            3: suspend_req = 1;
            4: resume_req = 1;
            5: done_in = 1;
            6: pulse_limit = 1;
            default: reset_cmd = 1;
        endcase
        @(negedge clk);
        start_erase = 0; start_prog = 0; prog_bad = 0; suspend_req = 0;
        resume_req = 0; done_in = 0; pulse_limit = 0; reset_cmd = 0;
    endtask

    task automatic rchk(input logic [SAW-1:0] s, input bit t6en, input bit t2en,
                        input int hold, input bit by_cs, input string req);
        rd_sect = s; cs_n = 0; oe_n = 0;
        @(negedge clk);
        chk(req, stat_word, ew());
        repeat (hold) @(negedge clk);
        if (by_cs) cs_n = 1; else oe_n = 1;
        @(negedge clk);
        cs_n = 1; oe_n = 1;
        if (t6en) e6 = ~e6;
        if (t2en && selb[s]) e2 = ~e2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 drive", stat_drive, 0);
        chk("R1 word", stat_word, 0);
        chk("R1 mask", erase_sectors, 0);

        // erase with one protected selected sector
        sel_mask = 4'b0110; prot_mask = 4'b0010; selb = 4'b0110;
        pulse(0);
        chk("R5 window drive", stat_drive, 1);
        chk("R5 window word", stat_word, ew());
        chk("R7 window mask", erase_sectors, 0);
        sel_mask = 4'b1111;
        repeat (TO - 1) @(negedge clk);
        chk("R5 window end", stat_word[3], 0);
        @(negedge clk);
        b3 = 1;
        chk("R5 timer set", stat_word[3], 1);
        chk("R7 erase mask", erase_sectors, 4'b0100);
        rchk(0, 1, 1, 0, 0, "R2 any sector");
        rchk(1, 1, 1, 0, 0, "R4 protected selected");
        rchk(2, 1, 1, 3, 0, "R2 long read");
        rchk(3, 1, 1, 0, 1, "R2 cs ended");
        rchk(2, 1, 1, 0, 0, "R4 after cs");
        pulse(7);
        chk("R10 reset ignored drive", stat_drive, 1);
        chk("R10 reset ignored word", stat_word, ew());
        pulse(3);
        chk("R11 suspend word", stat_word, ew());
        chk("R7 suspend mask", erase_sectors, 0);
        rchk(1, 0, 1, 0, 0, "R3 suspend sel");
        rchk(0, 0, 1, 0, 0, "R4 suspend unsel");
        rchk(2, 0, 1, 0, 0, "R3 suspend sel2");
        rchk(3, 0, 1, 0, 0, "R3 suspend hold");
        pulse(4);
        chk("R11 resume mask", erase_sectors, 4'b0100);
        rchk(2, 1, 1, 0, 0, "R11 resumed");
        rchk(0, 1, 1, 0, 0, "R2 resumed");
        pulse(5);
        b3 = 0;
        chk("R11 done drive", stat_drive, 0);
        chk("R1 idle word", stat_word, 0);

        // program, then pulse limit failure
        pulse(1);
        chk("R11 prog drive", stat_drive, 1);
        rchk(1, 1, 0, 0, 0, "R2 prog");
        rchk(2, 1, 0, 0, 0, "R4 prog quiet");
        pulse(6);
        f5 = 1;
        chk("R8 prog fail", stat_word, ew());
        rchk(2, 1, 0, 0, 0, "R2 fail toggles");
        repeat (5) @(negedge clk);
        chk("R10 fail sticky", stat_word, ew());
        pulse(7);
        f5 = 0;
        chk("R10 reset leaves fail", stat_drive, 0);

        // bad program
        pulse(2);
        f5 = 1;
        chk("R9 bad prog", stat_word, ew());
        pulse(7);
        f5 = 0;
        chk("R9 reset", stat_drive, 0);
        pulse(1);
        pulse(5);
        chk("R11 prog done", stat_drive, 0);

        // every selected sector protected
        sel_mask = 4'b0011; prot_mask = 4'b0111; selb = 4'b0011;
        pulse(0);
        chk("R6 wait drive", stat_drive, 1);
        chk("R6 wait word", stat_word, ew());
        chk("R6 no erase", erase_sectors, 0);
        repeat (PW - 1) @(negedge clk);
        chk("R6 wait last", stat_drive, 1);
        @(negedge clk);
        chk("R6 wait over", stat_drive, 0);
        pulse(0);
        rchk(0, 1, 0, 0, 0, "R6 toggles");
        rchk(1, 1, 0, 0, 0, "R6 toggles2");
        rchk(3, 1, 0, 0, 0, "R6 toggles3");
        repeat (PW) @(negedge clk);
        chk("R6 back idle", stat_drive, 0);

        // erase failure
        sel_mask = 4'b1000; prot_mask = 4'b0000; selb = 4'b1000;
        pulse(0);
        repeat (TO) @(negedge clk);
        pulse(6);
        f5 = 1;
        chk("R8 erase fail", stat_word, ew());
        pulse(7);
        f5 = 0;

        // sweep all selected masks over all sectors
        for (int m = 1; m < 16; m++) begin
            sel_mask = m[3:0];
            prot_mask = (m == 8) ? 4'b0000 : (m[3:0] & 4'b1000);
            selb = m[3:0];
            pulse(0);
            repeat (TO) @(negedge clk);
            b3 = 1;
            chk("R7 sweep mask", erase_sectors, m[3:0] & ~prot_mask);
            for (int s = 0; s < NS; s++) begin
                rchk(s[SAW-1:0], 1, 1, 0, 0, "R4 sweep");
            end
            pulse(5);
            b3 = 0;
            chk("R11 sweep done", stat_drive, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule